// File: doc/BRIEF.md
# CRC-Checked SPI Register Frame Master

This block lets on-chip logic read and write the 16-bit registers of an external sensor over a four-wire SPI link. The host offers one request at a time: a register address, a direction flag and, for a write, a data word. The block packs these into a 32-bit frame, adds a checksum byte and shifts the frame out with the clock idling low. Data leaves on the falling clock edge and is captured on the rising edge.

The sensor answers each frame during the frame that follows it. So every request is really a pair of frames. First the block sends the request frame. It then releases chip select and waits a fixed quiet interval. Then it sends a harmless filler read whose only job is to clock the answer back. From that second frame the block recovers the 16-bit answer as a signed value. It also recomputes the checksum and decodes the two status bits. It reports all of these together in a single-cycle completion pulse.

Two parameters set the timing. The serial clock half period is given in system clocks. The quiet time that chip select must stay high between any two frames is given as a count of system clocks. With a 100 MHz system clock, the default of 1000 cycles gives 10 µs.

Top module: `spi_frame_master`

## Requirements
- R1: A request frame is 32 bits, sent most significant bit first. Bits [31:24] hold the command: bit 31 is 1 for a write and 0 for a read, bits [30:26] carry the register address, and bits [25:24] are 0. Bits [23:8] hold the write data, high byte first; they are all zero for a read. Bits [7:0] hold the checksum.
- R2: The checksum is computed over frame bits [31:8], most significant bit first. It is a CRC-8 with polynomial 0x1D, a register seeded to 0xFF, and the final value bit-inverted.
- R3: Every request frame is followed by exactly one reply frame. The reply frame is a read of address FILL_ADDR (default 0) with a valid checksum. The response fields come only from the bits received during that reply frame.
- R4: spi_sclk is low whenever spi_cs_n is high. Each high phase of spi_sclk lasts HALF_DIV system clocks. spi_miso is sampled on the rising edge, and spi_mosi changes only on the falling edge or when chip select falls.
- R5: Between the end of any frame and the start of the next, spi_cs_n stays high for at least GAP_CYCLES system clocks. This holds inside a pair and between pairs.
- R6: req_ready is high only when no frame pair is in progress. A req_valid presented while busy is not taken and causes no frame. Each accepted request produces exactly two frames.
- R7: rsp_done is a one-cycle pulse after the reply frame ends. With it, rsp_data carries bits [23:8] received in the reply frame, as a signed 16-bit value.
- R8: rsp_crc_err is 1 exactly when received bits [7:0] differ from the inverted CRC-8 of received bits [31:8].
- R9: rsp_status_err is 1 exactly when received bits [25:24] equal 2'b11. rsp_data is still returned in that case.
- R10: While reset is active, and in the first cycle after it: spi_cs_n=1, spi_sclk=0, rsp_done=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes the request this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Signed data from the reply frame |
| rsp_crc_err | output | 1 | Reply checksum mismatch |
| rsp_status_err | output | 1 | Reply status field reports a device error |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The bench models the sensor behaviourally on the serial pins. Its model answers one frame late, so a design that took its data from the request frame would return the answer to the previous pair and fail the data checks. A wrong seed, a wrong bit order or a missing inversion in the checksum shows up in two places: the model rejects the outgoing frames, and clean replies raise a false checksum error. Replies are sent with a corrupted checksum, with status 2'b11, and with both, to confirm that each flag rises independently and that the data still arrives. Some requests are made while a pair is in progress; a block that took them would produce extra frames or overwrite a register, and a later read-back would show it.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int FRAME_BITS = 32;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 16;
    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_SEED = 8'hFF;
    localparam logic [1:0] STATUS_DEV_ERR = 2'b11;

    // Command byte: direction, address, two low bits (zero on transmit,
    // return status on receive).
    typedef struct packed {
        logic                 wr;
        logic [ADDR_BITS-1:0] addr;
        logic [1:0]           st;
    } cmd_t;

    typedef struct packed {
        cmd_t                 cmd;
        logic [DATA_BITS-1:0] data;
        logic [7:0]           crc;
    } frame_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_GAP_A,
        SEQ_RPY,
        SEQ_GAP_B
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LO,
        SH_HI
    } shift_state_t;

    // Bitwise CRC-8, MSB first, seeded, result inverted.
    function automatic logic [7:0] crc8_inv(input logic [23:0] body);
        logic [7:0] c;
        c = CRC_SEED;
        for (int i = 23; i >= 0; i--) begin
            if (c[7] ^ body[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else                c = {c[6:0], 1'b0};
        end
        return ~c;
    endfunction

    function automatic frame_t build_frame(input logic wr,
                                           input logic [ADDR_BITS-1:0] addr,
                                           input logic [DATA_BITS-1:0] data);
        frame_t f;
        f.cmd.wr   = wr;
        f.cmd.addr = addr;
        f.cmd.st   = 2'b00;
        f.data     = wr ? data : '0;
        f.crc      = crc8_inv({f.cmd, f.data});
        return f;
    endfunction

endpackage

// File: rtl/sfm_half_timer.sv
module sfm_half_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift
    import sfm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    output logic                  fin,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam int BW = $clog2(FRAME_BITS);

    shift_state_t          ph_q;
    logic [FRAME_BITS-1:0] sr_q;
    logic [BW-1:0]         bit_q;
    logic                  busy;
    logic                  tick;

    assign busy = (ph_q != SH_IDLE);
    assign mosi = sr_q[FRAME_BITS-1];

    sfm_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= SH_IDLE;
            sr_q    <= '0;
            bit_q   <= '0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            fin     <= 1'b0;
            rx_word <= '0;
        end else begin
            fin <= 1'b0;
            case (ph_q)
                SH_IDLE: if (start) begin
                    sr_q  <= tx_word;
                    bit_q <= '0;
                    cs_n  <= 1'b0;
                    ph_q  <= SH_LO;
                end
                SH_LO: if (tick) begin
                    sclk    <= 1'b1;
                    rx_word <= {rx_word[FRAME_BITS-2:0], miso};
                    ph_q    <= SH_HI;
                end
                SH_HI: if (tick) begin
                    sclk <= 1'b0;
                    if (bit_q == BW'(FRAME_BITS - 1)) begin
                        cs_n <= 1'b1;
                        fin  <= 1'b1;
                        ph_q <= SH_IDLE;
                    end else begin
                        sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
                        bit_q <= bit_q + 1'b1;
                        ph_q  <= SH_LO;
                    end
                end
                default: ph_q <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import sfm_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int GAP_CYCLES = 1000,
    parameter int FILL_ADDR  = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_BITS-1:0]        req_addr,
    input  logic [DATA_BITS-1:0]        req_wdata,
    output logic                        rsp_done,
    output logic signed [DATA_BITS-1:0] rsp_data,
    output logic                        rsp_crc_err,
    output logic                        rsp_status_err,
    output logic                        spi_sclk,
    output logic                        spi_cs_n,
    output logic                        spi_mosi,
    input  logic                        spi_miso
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    seq_state_t            st_q;
    logic [GW-1:0]         gap_q;
    frame_t                tx_q;
    logic                  start_q;
    logic                  fin;
    logic [FRAME_BITS-1:0] rx_word;
    frame_t                rx_f;
    logic                  gap_end;

    assign req_ready = (st_q == SEQ_IDLE);
    assign rx_f      = frame_t'(rx_word);
    assign gap_end   = (gap_q == GW'(GAP_CYCLES - 1));

    sfm_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start_q),
        .tx_word (tx_q),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .fin     (fin),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= SEQ_IDLE;
            gap_q          <= '0;
            tx_q           <= '0;
            start_q        <= 1'b0;
            rsp_done       <= 1'b0;
            rsp_data       <= '0;
            rsp_crc_err    <= 1'b0;
            rsp_status_err <= 1'b0;
        end else begin
            start_q  <= 1'b0;
            rsp_done <= 1'b0;
            case (st_q)
                SEQ_IDLE: if (req_valid) begin
                    tx_q    <= build_frame(req_write, req_addr, req_wdata);
                    start_q <= 1'b1;
                    st_q    <= SEQ_REQ;
                end
                SEQ_REQ: if (fin) begin
                    gap_q <= '0;
                    st_q  <= SEQ_GAP_A;
                end
                SEQ_GAP_A: begin
                    if (gap_end) begin
                        tx_q    <= build_frame(1'b0, ADDR_BITS'(FILL_ADDR), '0);
                        start_q <= 1'b1;
                        st_q    <= SEQ_RPY;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                SEQ_RPY: if (fin) begin
                    rsp_done       <= 1'b1;
                    rsp_data       <= rx_f.data;
                    rsp_crc_err    <= (rx_f.crc != crc8_inv(rx_word[FRAME_BITS-1:8]));
                    rsp_status_err <= (rx_f.cmd.st == STATUS_DEV_ERR);
                    gap_q          <= '0;
                    st_q           <= SEQ_GAP_B;
                end
                SEQ_GAP_B: begin
                    if (gap_end) st_q  <= SEQ_IDLE;
                    else         gap_q <= gap_q + 1'b1;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int GAP_CYCLES = 1000
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rsp_done,
    input logic spi_sclk,
    input logic spi_cs_n
);
    localparam int GCW = $clog2(GAP_CYCLES + 2);

    logic [GCW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst)                            hi_q <= GCW'(GAP_CYCLES);
        else if (!spi_cs_n)                 hi_q <= '0;
        else if (hi_q != GCW'(GAP_CYCLES))  hi_q <= hi_q + 1'b1;
    end

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R4
    sclk_rise_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> !spi_cs_n);

    // R5
    frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_q >= GCW'(GAP_CYCLES)));

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_cs_n && !spi_sclk && !rsp_done && req_ready));
endmodule

bind spi_frame_master sfm_checker #(.GAP_CYCLES(GAP_CYCLES)) u_sfm_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb;
    localparam int HALF_DIV = 2;
    localparam int GAP      = 1000;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_write = 1'b0;
    logic [4:0]         req_addr  = '0;
    logic [15:0]        req_wdata = '0;
    logic               rsp_done;
    logic signed [15:0] rsp_data;
    logic               rsp_crc_err;
    logic               rsp_status_err;
    logic               spi_sclk;
    logic               spi_cs_n;
    logic               spi_mosi;
    logic               spi_miso = 1'b0;

    spi_frame_master #(.HALF_DIV(HALF_DIV), .GAP_CYCLES(GAP), .FILL_ADDR(0)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .rsp_crc_err(rsp_crc_err), .rsp_status_err(rsp_status_err),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference checksum, integer arithmetic.
    function automatic logic [7:0] ref_crc(input logic [23:0] b);
        int c = 255;
        for (int k = 23; k >= 0; k--) begin
            int msb = (c >> 7) & 1;
            int din = (b >> k) & 1;
            c = (c << 1) & 255;
            if (msb != din) c = c ^ 29;
        end
        return ~c[7:0];
    endfunction

    function automatic logic [31:0] ref_frame(input bit wr, input logic [4:0] a,
                                              input logic [15:0] d);
        logic [23:0] body;
        body = {wr, a, 2'b00, (wr ? d : 16'h0000)};
        return {body, ref_crc(body)};
    endfunction

    // ---------------- sensor model (answers one frame late) ----------------
    logic [15:0] regs [32];
    logic [31:0] rx_sh = '0;
    logic [31:0] reply = '0;
    int          rx_bits = 0;
    int          tx_idx  = 0;
    logic [31:0] frames_q [$];
    bit          inj_crc = 0;
    bit          inj_rs  = 0;

    task automatic sensor_frame(input logic [31:0] f);
        logic [4:0]  a;
        logic [15:0] old;
        logic [1:0]  stv;
        logic [23:0] body;
        logic [7:0]  c;
        chk(f[7:0] == ref_crc(f[31:8]), "R2", "checksum of frame seen by sensor",
            {24'h0, f[7:0]}, {24'h0, ref_crc(f[31:8])});
        a   = f[30:26];
        old = regs[a];
        if (f[31]) regs[a] = f[23:8];
        stv  = inj_rs ? 2'b11 : 2'b01;
        body = {f[31:26], stv, old};
        c    = ref_crc(body);
        if (inj_crc) c = ~c;
        reply   = {body, c};
        inj_crc = 0;
        inj_rs  = 0;
    endtask

    always @(negedge spi_cs_n) begin
        rx_bits  = 0;
        tx_idx   = 0;
        spi_miso = reply[31];
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        rx_sh   = {rx_sh[30:0], spi_mosi};
        rx_bits = rx_bits + 1;
    end

    always @(negedge spi_sclk) if (!spi_cs_n && tx_idx < 31) begin
        tx_idx   = tx_idx + 1;
        spi_miso = reply[31 - tx_idx];
    end

    always @(posedge spi_cs_n) if (rx_bits == 32) begin
        frames_q.push_back(rx_sh);
        rx_bits = 0;
        sensor_frame(rx_sh);
    end

    // ---------------- per-cycle monitor ----------------
    int  cyc     = 0;
    int  hi_run  = GAP;
    int  sck_run = 0;
    bit  prev_cs = 1;
    bit  prev_sck = 0;
    bit  prev_done = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (!rst) begin
            chk(!(spi_cs_n && spi_sclk), "R4", "sclk high with cs_n high", {31'h0, spi_sclk}, 32'h0);
            chk(!(!spi_cs_n && req_ready), "R6", "ready while frame active", {31'h0, req_ready}, 32'h0);
            chk(!(prev_done && rsp_done), "R7", "done longer than one cycle", {31'h0, rsp_done}, 32'h0);
            if (prev_cs && !spi_cs_n)
                chk(hi_run >= GAP, "R5", "cs_n high cycles before frame", hi_run, GAP);
            if (prev_sck && !spi_sclk)
                chk(sck_run == HALF_DIV, "R4", "sclk high phase length", sck_run, HALF_DIV);
            hi_run  = spi_cs_n ? hi_run + 1 : 0;
            sck_run = spi_sclk ? sck_run + 1 : 0;
            prev_cs   = spi_cs_n;
            prev_sck  = spi_sclk;
            prev_done = rsp_done;
        end
    end

    // ---------------- transactions ----------------
    task automatic run_req(input bit wr, input logic [4:0] a, input logic [15:0] d,
                           input bit ic, input bit ir, input bit junk);
        logic [15:0] exp_old;
        int nfr;
        exp_old = regs[a];
        nfr     = frames_q.size();
        inj_crc = ic;
        inj_rs  = ir;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (junk) begin
            do @(negedge clk); while (spi_cs_n);
            req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 16'hAAAA;
            repeat (20) @(negedge clk);
            req_valid = 1'b0;
        end
        do @(negedge clk); while (!rsp_done);
        chk(rsp_data == exp_old, "R7", "reply data", {16'h0, rsp_data}, {16'h0, exp_old});
        chk(rsp_crc_err == ic, "R8", "checksum error flag", {31'h0, rsp_crc_err}, {31'h0, ic});
        chk(rsp_status_err == ir, "R9", "status error flag", {31'h0, rsp_status_err}, {31'h0, ir});
        chk(frames_q.size() == nfr + 2, "R3", "frames per request", frames_q.size(), nfr + 2);
        if (frames_q.size() >= nfr + 2) begin
            chk(frames_q[nfr] == ref_frame(wr, a, d), "R1", "request frame bits",
                frames_q[nfr], ref_frame(wr, a, d));
            chk(frames_q[nfr+1] == ref_frame(1'b0, 5'd0, 16'h0), "R3", "filler frame bits",
                frames_q[nfr+1], ref_frame(1'b0, 5'd0, 16'h0));
        end
        do @(negedge clk); while (!req_ready);
        chk(frames_q.size() == nfr + 2, "R6", "no extra frames while busy", frames_q.size(), nfr + 2);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 16'(i * 16'h0123 + 16'h0101);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R10", "cs_n in reset", {31'h0, spi_cs_n}, 32'h1);
        chk(spi_sclk == 1'b0, "R10", "sclk in reset", {31'h0, spi_sclk}, 32'h0);
        chk(rsp_done == 1'b0, "R10", "done in reset", {31'h0, rsp_done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", {31'h0, req_ready}, 32'h1);

        run_req(1'b1, 5'd5, 16'hBEEF, 0, 0, 0);
        run_req(1'b0, 5'd5, 16'h0000, 0, 0, 0);
        chk(rsp_data == -16'sd16657, "R7", "negative signed read-back", {16'h0, rsp_data}, 32'h0000BEEF);
        run_req(1'b1, 5'd31, 16'h7FFF, 0, 0, 0);
        run_req(1'b0, 5'd31, 16'h1234, 0, 0, 0);
        run_req(1'b0, 5'd9,  16'h0000, 1, 0, 0);
        run_req(1'b0, 5'd10, 16'h0000, 0, 1, 0);
        run_req(1'b0, 5'd11, 16'h0000, 1, 1, 0);
        run_req(1'b1, 5'd3,  16'h1234, 0, 0, 1);
        run_req(1'b0, 5'd3,  16'h0000, 0, 0, 0);
        chk(rsp_data == 16'sh1234, "R6", "busy request did not write", {16'h0, rsp_data}, 32'h1234);
        run_req(1'b0, 5'd0,  16'h0000, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule